// File: doc/BRIEF.md
# Dual-Port Parallel Interface Adapter

This peripheral gives a CPU two 8-bit bidirectional parallel ports, A and B, through a four-location register window. Each port has three registers. A direction mask sets which pins the block drives. An output register holds the values driven on those pins. A control register holds the port's mode bits and an event flag. The direction mask and the output register share one bus location, and a bit of that port's control register chooses between them.

Each port also has a control input line. An edge of the chosen polarity on this line, after synchronisation, sets the port's event flag. The flag can drive the port's active-low interrupt request, which is modelled as an open-drain output with its own output enable. When the request is disabled, software can still poll the flag. Reading the port's output location clears the flag.

The two request outputs can be tied together on a board. Software then reads both control registers to find which port raised the request.

Top module: `dual_pport_adapter`

## Requirements
- R1: After reset, every direction, output and control register is zero, so no pin is driven, no request is raised, and control reads return 0x00. While no read is in progress (cs and rdEn not both high), rdData is 0x00.
- R2: Address map: 0 is the port A data location, 1 is control A, 2 is the port B data location, 3 is control B. When control bit 2 is 0, the port's data location reads and writes its direction mask. A 1 in bit n of the mask drives pin n, and the pin's output enable equals the mask bit.
- R3: When control bit 2 is 1, the port's data location writes the output register. The portXOut pins show that register from the next clock edge, so an input-configured bit is never driven.
- R4: When control bit 2 is 1, a read of the port's data location returns the output register for bits whose mask bit is 1. For bits whose mask bit is 0, it returns the pin level sampled through two flip-flops.
- R5: Control bit 1 selects the active edge of the control line, 0 for falling and 1 for rising. Only that edge sets control bit 7, and the flag reads as 1 from the third rising clock edge after the line changes.
- R6: Writes to a control register store bits 6..0, and bit 7 of the written value is ignored.
- R7: A read of the data location while control bit 2 is 1 clears bit 7 at that clock edge. A read of the direction mask or of the control register leaves bit 7 unchanged.
- R8: If a flag-setting edge and a clearing read fall on the same clock edge, bit 7 stays 1.
- R9: Control bit 0 enables the request. irqXOe is 1 and irqXLow is 0 exactly when bit 7 and bit 0 are both 1. With bit 0 at 0, bit 7 still sets and reads back.
- R10: The two ports are independent. Bus accesses and line edges on one port never change the other port's registers, flag or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 2 | Register location |
| wrData | input | PORT_W | Write data |
| rdData | output | PORT_W | Read data, zero when not reading |
| portAIn | input | PORT_W | Port A pin levels |
| portAOut | output | PORT_W | Port A drive values |
| portAOe | output | PORT_W | Port A per-pin output enable |
| ctlLineA | input | 1 | Port A control input line |
| irqALow | output | 1 | Port A request level, active low |
| irqAOe | output | 1 | Port A open-drain request enable |
| portBIn | input | PORT_W | Port B pin levels |
| portBOut | output | PORT_W | Port B drive values |
| portBOe | output | PORT_W | Port B per-pin output enable |
| ctlLineB | input | 1 | Port B control input line |
| irqBLow | output | 1 | Port B request level, active low |
| irqBOe | output | 1 | Port B open-drain request enable |

## Verification
The hardest case to reach is a clearing read that falls on the same clock edge as a flag-setting edge. The line edge reaches the flag only after the synchroniser stages, so the two events must be arranged to coincide. The stimulus changes the control line and lets exactly two clock edges pass, then issues the data read, so the set and the clear land together. A cycle-accurate behavioural model checks the flag on every cycle. A long random phase mixes edge polarity, mode changes, polls and clears on both ports at once, and the same model checks every cycle.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int NUM_PORTS  = 2;
  localparam int ADDR_W     = 2;
  localparam int PORT_IDX_W = 1;
  localparam int CTL_W      = 8;
  localparam int FLAG_BIT   = 7;
  localparam int SEL_BIT    = 2;
  localparam int EDGE_BIT   = 1;
  localparam int EN_BIT     = 0;

  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic wrCtl;
    logic rdOut;
  } portStb_t;

  typedef struct packed {
    logic                  rdOn;
    logic                  rdCtl;
    logic                  rdData;
    logic [PORT_IDX_W-1:0] rdPort;
  } rdSel_t;
endpackage

// File: rtl/dpa_ctrl.sv
module dpa_ctrl
  import dpa_pkg::*;
(
  input  logic                            cs,
  input  logic                            rdEn,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_PORTS-1:0]            dataSel,
  output portStb_t [NUM_PORTS-1:0]        stb,
  output rdSel_t                          rdSel
);
  logic isCtl;
  logic [PORT_IDX_W-1:0] portIdx;

  assign isCtl   = addr[0];
  assign portIdx = addr[ADDR_W-1];

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic hit;
      hit = cs && (portIdx == PORT_IDX_W'(p));
      stb[p].wrDir = hit && wrEn && !isCtl && !dataSel[p];
      stb[p].wrOut = hit && wrEn && !isCtl &&  dataSel[p];
      stb[p].wrCtl = hit && wrEn &&  isCtl;
      stb[p].rdOut = hit && rdEn && !isCtl &&  dataSel[p];
    end
  end

  always_comb begin
    rdSel.rdOn   = cs && rdEn;
    rdSel.rdCtl  = isCtl;
    rdSel.rdData = dataSel[portIdx];
    rdSel.rdPort = portIdx;
  end
endmodule

// File: rtl/dpa_port.sv
module dpa_port
  import dpa_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStb_t          stb,
  input  logic [PORT_W-1:0] wrData,
  input  logic [PORT_W-1:0] pinIn,
  input  logic              ctlLine,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe,
  output logic              irqOe,
  output logic              irqLow,
  output logic [PORT_W-1:0] dirView,
  output logic [PORT_W-1:0] dataView,
  output logic [CTL_W-1:0]  ctlView
);
  logic [PORT_W-1:0] dirReg, outReg, pinMeta, pinSync;
  logic [CTL_W-2:0]  ctlReg;
  logic              flag;
  logic              lineMeta, lineSync, lineLast;
  logic              riseSeen, fallSeen, setEv, irqReq;

  assign riseSeen = lineSync & ~lineLast;
  assign fallSeen = ~lineSync & lineLast;
  assign setEv    = ctlReg[EDGE_BIT] ? riseSeen : fallSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirReg   <= '0;
      outReg   <= '0;
      ctlReg   <= '0;
      flag     <= 1'b0;
      pinMeta  <= '0;
      pinSync  <= '0;
      lineMeta <= 1'b0;
      lineSync <= 1'b0;
      lineLast <= 1'b0;
    end else begin
      pinMeta  <= pinIn;
      pinSync  <= pinMeta;
      lineMeta <= ctlLine;
      lineSync <= lineMeta;
      lineLast <= lineSync;
      if (stb.wrDir) dirReg <= wrData;
      if (stb.wrOut) outReg <= wrData;
      if (stb.wrCtl) ctlReg <= wrData[CTL_W-2:0];
      // a new event wins over a clearing read on the same edge
      flag <= setEv | (flag & ~stb.rdOut);
    end
  end

  assign irqReq   = flag & ctlReg[EN_BIT];
  assign irqOe    = irqReq;
  assign irqLow   = ~irqReq;
  assign pinOut   = outReg;
  assign pinOe    = dirReg;
  assign dirView  = dirReg;
  assign dataView = (outReg & dirReg) | (pinSync & ~dirReg);
  assign ctlView  = {flag, ctlReg};
endmodule

// File: rtl/dpa_datapath.sv
module dpa_datapath
  import dpa_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  portStb_t [NUM_PORTS-1:0]            stb,
  input  rdSel_t                              rdSel,
  input  logic [PORT_W-1:0]                   wrData,
  input  logic [NUM_PORTS-1:0][PORT_W-1:0]    pinIn,
  input  logic [NUM_PORTS-1:0]                ctlLine,
  output logic [NUM_PORTS-1:0][PORT_W-1:0]    pinOut,
  output logic [NUM_PORTS-1:0][PORT_W-1:0]    pinOe,
  output logic [NUM_PORTS-1:0]                irqOe,
  output logic [NUM_PORTS-1:0]                irqLow,
  output logic [NUM_PORTS-1:0][CTL_W-1:0]     ctlView,
  output logic [PORT_W-1:0]                   rdData
);
  logic [NUM_PORTS-1:0][PORT_W-1:0] dirView, dataView;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : gPort
    dpa_port #(.PORT_W(PORT_W)) u_port (
      .clk     (clk),
      .rstN    (rstN),
      .stb     (stb[p]),
      .wrData  (wrData),
      .pinIn   (pinIn[p]),
      .ctlLine (ctlLine[p]),
      .pinOut  (pinOut[p]),
      .pinOe   (pinOe[p]),
      .irqOe   (irqOe[p]),
      .irqLow  (irqLow[p]),
      .dirView (dirView[p]),
      .dataView(dataView[p]),
      .ctlView (ctlView[p])
    );
  end

  always_comb begin
    rdData = '0;
    if (rdSel.rdOn) begin
      if (rdSel.rdCtl)       rdData = PORT_W'(ctlView[rdSel.rdPort]);
      else if (rdSel.rdData) rdData = dataView[rdSel.rdPort];
      else                   rdData = dirView[rdSel.rdPort];
    end
  end
endmodule

// File: rtl/dual_pport_adapter.sv
module dual_pport_adapter
  import dpa_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cs,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wrData,
  output logic [PORT_W-1:0] rdData,
  input  logic [PORT_W-1:0] portAIn,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portAOe,
  input  logic              ctlLineA,
  output logic              irqALow,
  output logic              irqAOe,
  input  logic [PORT_W-1:0] portBIn,
  output logic [PORT_W-1:0] portBOut,
  output logic [PORT_W-1:0] portBOe,
  input  logic              ctlLineB,
  output logic              irqBLow,
  output logic              irqBOe
);
  portStb_t [NUM_PORTS-1:0]             stb;
  rdSel_t                               rdSel;
  logic [NUM_PORTS-1:0]                 dataSel;
  logic [NUM_PORTS-1:0][CTL_W-1:0]      ctlView;
  logic [NUM_PORTS-1:0][PORT_W-1:0]     pinInArr, pinOutArr, pinOeArr;
  logic [NUM_PORTS-1:0]                 irqOeArr, irqLowArr;

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) dataSel[p] = ctlView[p][SEL_BIT];
  end

  assign pinInArr = {portBIn, portAIn};

  dpa_ctrl u_ctrl (
    .cs     (cs),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .addr   (addr),
    .dataSel(dataSel),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  dpa_datapath #(.PORT_W(PORT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .rdSel  (rdSel),
    .wrData (wrData),
    .pinIn  (pinInArr),
    .ctlLine({ctlLineB, ctlLineA}),
    .pinOut (pinOutArr),
    .pinOe  (pinOeArr),
    .irqOe  (irqOeArr),
    .irqLow (irqLowArr),
    .ctlView(ctlView),
    .rdData (rdData)
  );

  assign portAOut = pinOutArr[0];
  assign portBOut = pinOutArr[1];
  assign portAOe  = pinOeArr[0];
  assign portBOe  = pinOeArr[1];
  assign irqAOe   = irqOeArr[0];
  assign irqBOe   = irqOeArr[1];
  assign irqALow  = irqLowArr[0];
  assign irqBLow  = irqLowArr[1];
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cs,
  input logic              rdEn,
  input logic              wrEn,
  input logic [1:0]        addr,
  input logic [PORT_W-1:0] wrData,
  input logic [PORT_W-1:0] rdData,
  input logic [PORT_W-1:0] portAOe,
  input logic [PORT_W-1:0] portBOut,
  input logic              irqBOe,
  input logic [7:0]        ctlViewA,
  input logic [7:0]        ctlViewB
);
  a_r1_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(cs && rdEn) |-> rdData == '0);

  a_r2_dir_write_drives_oe: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wrEn && addr == 2'd0 && !ctlViewA[2]) |=> portAOe == $past(wrData));

  a_r3_out_write_reaches_pins: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wrEn && addr == 2'd2 && ctlViewB[2]) |=> portBOut == $past(wrData));

  a_r6_ctl_write_low_bits: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wrEn && addr == 2'd1) |=> ctlViewA[6:0] == $past(wrData[6:0]));

  a_r7_flag_a_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ctlViewA[7] && !(cs && rdEn && addr == 2'd0 && ctlViewA[2])) |=> ctlViewA[7]);

  a_r10_flag_b_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ctlViewB[7] && !(cs && rdEn && addr == 2'd2 && ctlViewB[2])) |=> ctlViewB[7]);

  a_r9_disable_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (cs && wrEn && addr == 2'd3 && !wrData[0]) |=> !irqBOe);
endmodule

bind dual_pport_adapter dpa_checker #(.PORT_W(PORT_W)) u_dpaChk (
  .clk     (clk),
  .rstN    (rstN),
  .cs      (cs),
  .rdEn    (rdEn),
  .wrEn    (wrEn),
  .addr    (addr),
  .wrData  (wrData),
  .rdData  (rdData),
  .portAOe (portAOe),
  .portBOut(portBOut),
  .irqBOe  (irqBOe),
  .ctlViewA(ctlView[0]),
  .ctlViewB(ctlView[1])
);

// File: tb/test_dual_pport_adapter.sv
`timescale 1ns/1ps
module test_dual_pport_adapter;
  localparam real HALF = 2.5;

  logic       clk = 1'b0;
  logic       rstN, cs, rdEn, wrEn;
  logic [1:0] addr;
  logic [7:0] wrData;
  logic [7:0] pinIn [2];
  logic [1:0] lineIn;
  logic [7:0] rdData, portAOut, portAOe, portBOut, portBOe;
  logic       irqALow, irqAOe, irqBLow, irqBOe;

  int    vecCount = 0;
  int    failCount = 0;
  string curTag = "R1";

  // behavioural reference state
  logic [7:0] mDir [2], mOut [2], mCtl [2];
  logic       mFlag [2];
  logic [7:0] pinQ [2][$];
  logic       lineQ [2][$];

  always #(HALF) clk = ~clk;

  dual_pport_adapter #(.PORT_W(8)) i_dual_pport_adapter (
    .clk(clk), .rstN(rstN), .cs(cs), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData),
    .portAIn(pinIn[0]), .portAOut(portAOut), .portAOe(portAOe),
    .ctlLineA(lineIn[0]), .irqALow(irqALow), .irqAOe(irqAOe),
    .portBIn(pinIn[1]), .portBOut(portBOut), .portBOe(portBOe),
    .ctlLineB(lineIn[1]), .irqBLow(irqBLow), .irqBOe(irqBOe)
  );

  // pin value seen two edges ago; line values one and two edges before that
  function automatic logic [7:0] pinSeen(int p);
    return pinQ[p][0];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < 2; p++) begin
        mDir[p] = 0; mOut[p] = 0; mCtl[p] = 0; mFlag[p] = 0;
        pinQ[p] = '{8'h00, 8'h00};
        lineQ[p] = '{1'b0, 1'b0, 1'b0};
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        logic hit, ev, clr, newer, older;
        newer = lineQ[p][1];
        older = lineQ[p][0];
        hit = cs && (int'(addr[1]) == p);
        ev  = mCtl[p][1] ? (newer && !older) : (!newer && older);
        clr = hit && rdEn && !addr[0] && mCtl[p][2];
        mFlag[p] = ev || (mFlag[p] && !clr);
        if (hit && wrEn) begin
          if (addr[0])        mCtl[p] = wrData & 8'h7F;
          else if (mCtl[p][2]) mOut[p] = wrData;
          else                 mDir[p] = wrData;
        end
        void'(lineQ[p].pop_front());
        lineQ[p].push_back(lineIn[p]);
        void'(pinQ[p].pop_front());
        pinQ[p].push_back(pinIn[p]);
      end
    end
  end

  task automatic check(string name, logic [7:0] act, logic [7:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", curTag, name, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] eRd;
    int p;
    eRd = 0;
    if (cs && rdEn) begin
      p = int'(addr[1]);
      if (addr[0])        eRd = {mFlag[p], mCtl[p][6:0]};
      else if (mCtl[p][2]) eRd = (mOut[p] & mDir[p]) | (pinSeen(p) & ~mDir[p]);
      else                 eRd = mDir[p];
    end
    check("rdData", rdData, eRd);
    check("portAOut", portAOut, mOut[0]);
    check("portAOe", portAOe, mDir[0]);
    check("portBOut", portBOut, mOut[1]);
    check("portBOe", portBOe, mDir[1]);
    check("irqAOe", {7'd0, irqAOe}, {7'd0, mFlag[0] & mCtl[0][0]});
    check("irqALow", {7'd0, irqALow}, {7'd0, !(mFlag[0] & mCtl[0][0])});
    check("irqBOe", {7'd0, irqBOe}, {7'd0, mFlag[1] & mCtl[1][0]});
    check("irqBLow", {7'd0, irqBLow}, {7'd0, !(mFlag[1] & mCtl[1][0])});
  endtask

  task automatic tick();
    #1;
    if (rstN) compare();
    @(negedge clk);
  endtask

  task automatic busIdle();
    cs = 0; rdEn = 0; wrEn = 0; addr = 0; wrData = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cs = 1; wrEn = 1; rdEn = 0; addr = a; wrData = d;
    tick();
    busIdle();
  endtask

  task automatic rd(logic [1:0] a);
    cs = 1; rdEn = 1; wrEn = 0; addr = a;
    tick();
    busIdle();
  endtask

  task automatic idle(int n);
    repeat (n) tick();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  endtask

  initial begin
    #(HALF * 2 * 200000);
    curTag = "watchdog";
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    busIdle();
    pinIn[0] = 0; pinIn[1] = 0; lineIn = 0;
    rstN = 0;
    @(negedge clk);
    idle(3);
    rstN = 1;

    curTag = "R1";                       // reset contents and quiet bus
    idle(2);
    rd(0); rd(1); rd(2); rd(3);

    curTag = "R2";                       // direction masks through offsets 0 and 2
    wr(0, 8'hF0); wr(2, 8'h3C);
    rd(0); rd(2); idle(1);

    curTag = "R3";                       // output registers after selecting data
    wr(1, 8'h04); wr(3, 8'h04);
    wr(0, 8'hA5); wr(2, 8'h5A);
    idle(2);

    curTag = "R4";                       // merged readback with two-stage pin sampling
    pinIn[0] = 8'h3C; pinIn[1] = 8'hC3;
    rd(0); rd(2);
    idle(3);
    rd(0); rd(2);

    curTag = "R6";                       // bit 7 written as 1 is ignored
    wr(1, 8'h84); rd(1);

    curTag = "R5";                       // falling mode ignores a rise, sets on a fall
    lineIn[0] = 1; idle(5); rd(1);
    lineIn[0] = 0; idle(1); rd(1); idle(1); rd(1);
    rd(0);
    wr(1, 8'h06);                        // rising mode
    lineIn[0] = 1; idle(4); rd(1);
    rd(0); rd(1);

    curTag = "R7";                       // direction or control reads keep the flag
    lineIn[0] = 0; wr(1, 8'h04); idle(4); rd(1);
    wr(1, 8'h00); rd(0); rd(1);
    wr(1, 8'h04); rd(1); rd(0); rd(1);

    curTag = "R9";                       // enable gates request, flag still pollable
    lineIn[0] = 1; idle(4); lineIn[0] = 0; idle(4);
    rd(1);
    wr(1, 8'h05); idle(2);
    wr(1, 8'h04); rd(1);
    wr(1, 8'h05); rd(0); idle(2);

    curTag = "R8";                       // set and clear on the same edge
    lineIn[0] = 1; idle(4);
    lineIn[0] = 0; tick(); tick();
    rd(0);
    rd(1);
    rd(0); rd(1);

    curTag = "R10";                      // port B events leave port A alone
    wr(3, 8'h07);
    lineIn[1] = 1; idle(4);
    rd(1); rd(3);
    lineIn[0] = 1; idle(1); lineIn[0] = 0; idle(4);
    rd(1); rd(3); rd(2); rd(1); rd(3);
    rd(0); rd(3);

    curTag = "R4";                       // random mixed traffic on both ports
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) lineIn[$urandom_range(0, 1)] ^= 1'b1;
      if ($urandom_range(0, 7) == 0) pinIn[$urandom_range(0, 1)] = 8'($urandom);
      if (op < 3)      wr(2'($urandom), 8'($urandom));
      else if (op < 7) rd(2'($urandom));
      else             tick();
    end

    finishRun();
  end
endmodule